// File: doc/BRIEF.md
# Immediate-Operand Arithmetic and Logic Unit

This block executes the immediate-operand integer instructions of a 32-bit processor core. Two instruction classes share it. The full-immediate class combines a source operand with a separate 32-bit immediate word, using OR, AND, XOR, subtract, add or compare. The quick class adds or subtracts a small constant packed into the instruction word itself. Every operation also produces the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C).

The surrounding pipeline fetches the operand, decodes the addressing mode and owns the register file. It presents one operation per cycle with `in_valid`. One clock later the block returns the result, a write-back enable, the updated flags and a strobe for an undefined operation code. A single adder/subtractor serves both classes. All outputs come from registers with a synchronous active-high reset.

Top module: `imm_alu`

## Requirements
- R1: With `is_quick`=0, `instr[11:9]` selects the operation: 0 OR, 1 AND, 2 SUB (src minus imm), 3 ADD, 5 XOR, 6 CMP. `result` carries the value computed, and `wr_en`=1 for every selected operation except CMP.
- R2: With `is_quick`=0, `instr[11:9]` equal to 4 or 7 raises `undef`. In that case `wr_en`=0, `result`=0 and `flags_out` equals `flags_in`.
- R3: CMP forms src minus imm. It sets N, Z, V and C as SUB does, holds `wr_en` at 0 and copies X from `flags_in`.
- R4: OR, AND and XOR take N from result bit 31 and set Z when the result is zero. They clear V and C and copy X from `flags_in`.
- R5: For ADD and SUB, C is the carry out or the unsigned borrow (src < operand), and V is two's-complement overflow. X is given the same value as C. N and Z follow the result as in R4.
- R6: With `is_quick`=1, the operand is `instr[11:9]`, where the code 0 stands for 8. `instr[8]`=1 selects subtract and 0 selects add. Flags follow R5, and `wr_en`=1.
- R7: With `is_quick`=1 and `instr[5:3]`=3'b001 (an address-register destination), the result is still written (`wr_en`=1), but `flags_out` equals `flags_in`.
- R8: Outputs appear one clock after the inputs: `out_valid` follows `in_valid` with one cycle of delay. `wr_en` and `undef` are 0 in any cycle where `out_valid` is 0. `result` and `flags_out` hold their values during idle cycles.
- R9: After a synchronous reset, `out_valid`, `wr_en`, `undef`, `result` and `flags_out` are all 0. The flag bits are packed as {X,N,Z,V,C}, with X in bit 4 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| is_quick | input | 1 | 1 = quick class, 0 = full-immediate class |
| instr | input | 16 | Instruction word |
| imm | input | 32 | Immediate for the full-immediate class |
| src | input | 32 | Source/destination operand value |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result stage holds an operation |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Write result back to the destination |
| flags_out | output | 5 | New flags {X,N,Z,V,C} |
| undef | output | 1 | Undefined operation code strobe |

## Verification
Two functions can act in the same cycle: the arithmetic flag update from the shared adder and a rule that suppresses part of it. One case is a quick subtract that borrows while aimed at an address register, which must write the borrowed result yet leave every flag alone. The other is a CMP that overflows, which must produce the SUB flags but keep X and drop the write. The bench drives these collisions in directed cases with carries and borrows forced at the 32-bit boundary. It then adds a long random stream, in which they recur naturally. A behavioural reference model built on wide integers judges every output field on every cycle.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [2:0] {
    FOP_OR   = 3'd0,
    FOP_AND  = 3'd1,
    FOP_SUB  = 3'd2,
    FOP_ADD  = 3'd3,
    FOP_RSV4 = 3'd4,
    FOP_XOR  = 3'd5,
    FOP_CMP  = 3'd6,
    FOP_RSV7 = 3'd7
  } fop_e;

  typedef enum logic [1:0] {
    RSEL_OR,
    RSEL_AND,
    RSEL_XOR,
    RSEL_ARITH
  } rsel_e;

  typedef enum logic [1:0] {
    FUPD_KEEP,
    FUPD_LOGIC,
    FUPD_ARITH,
    FUPD_ARITH_HOLDX
  } fupd_e;

endpackage

// File: rtl/imm_alu_dec.sv
module imm_alu_dec
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 16
) (
  input  logic              is_quick,
  input  logic [INSN_W-1:0] instr,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] opnd_b,
  output logic              do_sub,
  output rsel_e             rsel,
  output fupd_e             fupd,
  output logic              wr,
  output logic              bad_op
);
  localparam int QW = 4;

  fop_e           fop;
  logic [QW-1:0]  qval;
  logic           to_areg;

  assign fop     = fop_e'(instr[11:9]);
  assign qval    = (instr[11:9] == 3'd0) ? QW'(8) : {1'b0, instr[11:9]};
  assign to_areg = (instr[5:3] == 3'b001);

  always_comb begin
    opnd_b = imm;
    do_sub = 1'b0;
    rsel   = RSEL_ARITH;
    fupd   = FUPD_KEEP;
    wr     = 1'b0;
    bad_op = 1'b0;
    if (is_quick) begin
      opnd_b = DATA_W'(qval);
      do_sub = instr[8];
      wr     = 1'b1;
      fupd   = to_areg ? FUPD_KEEP : FUPD_ARITH;
    end else begin
      unique case (fop)
        FOP_OR:  begin rsel = RSEL_OR;  fupd = FUPD_LOGIC; wr = 1'b1; end
        FOP_AND: begin rsel = RSEL_AND; fupd = FUPD_LOGIC; wr = 1'b1; end
        FOP_XOR: begin rsel = RSEL_XOR; fupd = FUPD_LOGIC; wr = 1'b1; end
        FOP_SUB: begin do_sub = 1'b1; fupd = FUPD_ARITH; wr = 1'b1; end
        FOP_ADD: begin fupd = FUPD_ARITH; wr = 1'b1; end
        FOP_CMP: begin do_sub = 1'b1; fupd = FUPD_ARITH_HOLDX; end
        default: bad_op = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/imm_alu_addsub.sv
module imm_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cy,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum   = wide[MSB:0];
  assign cy    = sub ? ~wide[DATA_W] : wide[DATA_W];
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/imm_alu_logic.sv
module imm_alu_logic
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] arith,
  input  rsel_e             sel,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        RSEL_OR:  y[i] = a[i] | b[i];
        RSEL_AND: y[i] = a[i] & b[i];
        RSEL_XOR: y[i] = a[i] ^ b[i];
        default:  y[i] = arith[i];
      endcase
    end
  end

endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 16,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              is_quick,
  input  logic [INSN_W-1:0] instr,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] src,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [FLAG_W-1:0] flags_out,
  output logic              undef
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opnd_b;
  logic              do_sub;
  rsel_e             rsel;
  fupd_e             fupd;
  logic              wr;
  logic              bad_op;
  logic [DATA_W-1:0] sum;
  logic              cy;
  logic              ovf;
  logic [DATA_W-1:0] res_c;
  flags_t            fin;
  flags_t            fnew;
  logic              z_c;

  imm_alu_dec #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_dec (
    .is_quick (is_quick),
    .instr    (instr),
    .imm      (imm),
    .opnd_b   (opnd_b),
    .do_sub   (do_sub),
    .rsel     (rsel),
    .fupd     (fupd),
    .wr       (wr),
    .bad_op   (bad_op)
  );

  imm_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a   (src),
    .b   (opnd_b),
    .sub (do_sub),
    .sum (sum),
    .cy  (cy),
    .ovf (ovf)
  );

  imm_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a     (src),
    .b     (opnd_b),
    .arith (sum),
    .sel   (rsel),
    .y     (res_c)
  );

  assign fin = flags_t'(flags_in);
  assign z_c = ~|res_c;

  always_comb begin
    fnew = fin;
    unique case (fupd)
      FUPD_LOGIC:       fnew = '{x: fin.x, n: res_c[MSB], z: z_c, v: 1'b0, c: 1'b0};
      FUPD_ARITH:       fnew = '{x: cy,    n: res_c[MSB], z: z_c, v: ovf,  c: cy};
      FUPD_ARITH_HOLDX: fnew = '{x: fin.x, n: res_c[MSB], z: z_c, v: ovf,  c: cy};
      default:          fnew = fin;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      undef     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_en     <= wr & ~bad_op;
        undef     <= bad_op;
        result    <= bad_op ? '0 : res_c;
        flags_out <= FLAG_W'(fnew);
      end else begin
        wr_en <= 1'b0;
        undef <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
  parameter int DATA_W = 32,
  parameter int INSN_W = 16,
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              is_quick,
  input logic [INSN_W-1:0] instr,
  input logic [DATA_W-1:0] imm,
  input logic [DATA_W-1:0] src,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [FLAG_W-1:0] flags_out,
  input logic              undef
);
  logic full_v;
  assign full_v = in_valid && !is_quick;

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    undef |-> !wr_en) else $error("undef with write"); // R2

  AST_UNDEF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (full_v && (instr[11:9] == 3'd4 || instr[11:9] == 3'd7))
      |=> (undef && flags_out == $past(flags_in))) else $error("undef flags"); // R2

  AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full_v && instr[11:9] == 3'd6)
      |=> (!wr_en && flags_out[4] == $past(flags_in[4]))) else $error("cmp"); // R3

  AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (rst)
    (full_v && (instr[11:9] == 3'd0 || instr[11:9] == 3'd1 || instr[11:9] == 3'd5))
      |=> (flags_out[1:0] == 2'b00)) else $error("logic vc"); // R4

  AST_AREG_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_quick && instr[5:3] == 3'b001)
      |=> (wr_en && flags_out == $past(flags_in))) else $error("areg"); // R7

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid lost"); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wr_en && !undef)) else $error("idle strobe"); // R8

endmodule

bind imm_alu imm_alu_chk #(.DATA_W(DATA_W), .INSN_W(INSN_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/test_imm_alu.sv
module test_imm_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        is_quick = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] imm = '0;
  logic [31:0] src = '0;
  logic [4:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  flags_out;
  logic        undef;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic        e_valid = 0, e_wr = 0, e_undef = 0;
  logic [31:0] e_res = '0;
  logic [4:0]  e_flags = '0;
  string       e_tag = "R9";

  always #2.5 clk = ~clk;

  imm_alu i_imm_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_quick(is_quick),
    .instr(instr), .imm(imm), .src(src), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flags_out(flags_out), .undef(undef)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("out_valid", 32'(out_valid), 32'(e_valid));
    chk("wr_en", 32'(wr_en), 32'(e_wr));
    chk("undef", 32'(undef), 32'(e_undef));
    chk("result", result, e_res);
    chk("flags", 32'(flags_out), 32'(e_flags));
  endtask

  // Behavioural reference: flags packed {X,N,Z,V,C}
  task automatic model(input bit v, input bit q, input logic [15:0] ins,
                       input logic [31:0] im, input logic [31:0] s, input logic [4:0] f);
    longint a, b, r;
    bit sub, arith, holdx, logic_op, keep;
    int code;
    bit c, ov;
    e_valid = v;
    if (!v) begin
      e_wr = 0; e_undef = 0; e_tag = "R8";
      return;
    end
    a = longint'(s); code = int'(ins[11:9]);
    sub = 0; arith = 0; holdx = 0; logic_op = 0; keep = 0;
    e_undef = 0; e_wr = 1;
    if (q) begin
      b = (code == 0) ? 8 : code;
      sub = ins[8]; arith = 1;
      keep = (ins[5:3] == 3'b001);
      e_tag = keep ? "R7" : "R6";
    end else begin
      b = longint'(im);
      case (code)
        0: begin r = a | b; logic_op = 1; e_tag = "R4"; end
        1: begin r = a & b; logic_op = 1; e_tag = "R4"; end
        5: begin r = a ^ b; logic_op = 1; e_tag = "R4"; end
        2: begin sub = 1; arith = 1; e_tag = "R5"; end
        3: begin arith = 1; e_tag = "R5"; end
        6: begin sub = 1; arith = 1; holdx = 1; e_wr = 0; e_tag = "R3"; end
        default: begin e_undef = 1; e_wr = 0; e_tag = "R2"; end
      endcase
    end
    if (e_undef) begin
      e_res = 0; e_flags = f;
      return;
    end
    if (arith) begin
      if (sub) begin
        r = a - b; c = (a < b);
        ov = ($signed(s) - $signed(32'(b))) != longint'($signed(32'(a - b)));
      end else begin
        r = a + b; c = r[32];
        ov = (longint'($signed(s)) + longint'($signed(32'(b)))) != longint'($signed(32'(r)));
      end
    end
    e_res = r[31:0];
    if (keep) e_flags = f;
    else if (logic_op) e_flags = {f[4], e_res[31], e_res == 0, 1'b0, 1'b0};
    else e_flags = {holdx ? f[4] : c, e_res[31], e_res == 0, ov, c};
  endtask

  task automatic step(input bit v, input bit q, input logic [15:0] ins,
                      input logic [31:0] im, input logic [31:0] s, input logic [4:0] f);
    @(negedge clk);
    compare_all();
    in_valid = v; is_quick = q; instr = ins; imm = im; src = s; flags_in = f;
    model(v, q, ins, im, s, f);
  endtask

  // full-class instruction word with op code in bits 11:9
  function automatic logic [15:0] fw(int op);
    return 16'(op << 9);
  endfunction
  // quick word: value code, subtract bit, destination field bits 5:3
  function automatic logic [15:0] qw(int val, bit sb, int mode);
    return 16'((val << 9) | (int'(sb) << 8) | (mode << 3));
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9: reset state checked on first step
    step(1, 0, fw(0), 32'h0F0F_0000, 32'h0000_00F0, 5'b10000);  // R1 OR
    step(1, 0, fw(1), 32'hFFFF_0000, 32'h8000_1234, 5'b00011);  // R1 AND
    step(1, 0, fw(5), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'b10011);  // R4 XOR zero
    step(1, 0, fw(2), 32'h0000_0001, 32'h0000_0000, 5'b00000);  // R5 SUB borrow
    step(1, 0, fw(3), 32'h0000_0001, 32'h7FFF_FFFF, 5'b00000);  // R5 ADD overflow
    step(1, 0, fw(3), 32'h0000_0001, 32'hFFFF_FFFF, 5'b00000);  // R5 ADD carry zero
    step(1, 0, fw(2), 32'h0000_0001, 32'h8000_0000, 5'b10000);  // R5 SUB overflow
    step(1, 0, fw(6), 32'h0000_0001, 32'h8000_0000, 5'b00000);  // R3 CMP overflow, X kept
    step(1, 0, fw(6), 32'h1234_5678, 32'h1234_5678, 5'b10000);  // R3 CMP equal
    step(1, 0, fw(6), 32'h0000_0002, 32'h0000_0001, 5'b00000);  // R3 CMP borrow X held 0
    step(1, 0, fw(4), 32'h1111_1111, 32'h2222_2222, 5'b10101);  // R2 code 4
    step(1, 0, fw(7), 32'h1111_1111, 32'h2222_2222, 5'b01010);  // R2 code 7
    step(0, 0, fw(3), 32'h0, 32'h0, 5'b11111);                   // R8 idle hold
    step(1, 1, qw(0, 0, 0), 32'h0, 32'h0000_0010, 5'b11111);     // R6 value 0 means 8
    step(1, 1, qw(3, 1, 0), 32'h0, 32'h0000_0002, 5'b00000);     // R6 subtract borrow
    step(1, 1, qw(7, 0, 2), 32'h0, 32'hFFFF_FFF9, 5'b00000);     // R6 add carry to zero
    step(1, 1, qw(1, 1, 1), 32'h0, 32'h0000_0000, 5'b01010);     // R7 borrow, flags kept
    step(1, 1, qw(0, 0, 1), 32'h0, 32'h7FFF_FFFC, 5'b10101);     // R7 overflow, flags kept
    step(0, 1, qw(0, 0, 1), 32'h0, 32'h0, 5'b00000);             // R8 idle
    step(0, 0, fw(1), 32'h0, 32'h0, 5'b00000);                   // R8 idle again
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 8) != 0, $urandom % 2, 16'($urandom), $urandom,
           (($urandom % 4) == 0) ? 32'h7FFF_FFFF + 32'($urandom % 3) : $urandom,
           5'($urandom));
    end
    step(0, 0, 16'h0, 32'h0, 32'h0, 5'h0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule